// File: doc/BRIEF.md
# USB Device Interrupt Status and Mask Register

This block holds the interrupt status byte of a USB function controller. It takes single-cycle event strobes from the USB protocol engine and latches them as sticky flags. These are a detected bus reset, an IN token to endpoint 2 that found no data to send, and an accepted setup packet on endpoint 0. Two more bits of the byte track live FIFO conditions: endpoint 1 holding a received packet, and endpoint 2 having at least one free transmit buffer. Software cannot clear these two bits.

A CPU reaches the block over a minimal register bus with a one-bit address. Address 0 returns the status byte. Address 1 holds an 8-bit enable mask. To clear flags, software writes a byte to address 0 with a 0 in each bit it wants cleared and a 1 in each bit it wants kept. The block ANDs the flags with the mask, ORs the result, and registers it to drive a single interrupt request line.

Top module: `usb_irq_flags`

## Requirements
- R1: While reset is held, and at the first clock after it, the status byte reads 0x10 whatever the FIFO inputs are. The enable byte reads 0x00 and `irq` is 0.
- R2: Status bit 6 equals the value `ep1_rx_valid` had at the previous rising clock edge. Writes to address 0 have no effect on it.
- R3: Status bit 4 equals the value `ep2_tx_free` had at the previous rising clock edge. Writes to address 0 have no effect on it.
- R4: A one-cycle pulse sets a sticky flag at that clock edge, and the flag stays set afterwards. `bus_reset_evt` sets bit 7, `ep2_nodata_evt` sets bit 5 and `setup_done_evt` sets bit 3.
- R5: A write to address 0 (`addr`=0) clears each sticky flag whose data bit is 0. It leaves unchanged each sticky flag whose data bit is 1.
- R6: If an event pulse and a clearing write reach the same sticky flag in the same cycle, the flag ends up set.
- R7: Status bits 2 to 0 always read 0, including after writes of 1 to them.
- R8: A write to address 1 (`addr`=1) stores all 8 data bits in the enable mask. Reading address 1 returns that mask. Writes to address 0 leave the mask unchanged.
- R9: At every clock edge, `irq` takes the value of (status byte AND enable mask) != 0 as it was just before that edge. So `irq` lags any flag or mask change by exactly one clock.
- R10: `rdata` shows the status byte when `addr`=0 and the enable mask when `addr`=1, without any clock delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_reset_evt | input | 1 | One-cycle strobe: bus reset seen on the USB |
| ep2_nodata_evt | input | 1 | One-cycle strobe: IN token to endpoint 2 with no data ready |
| setup_done_evt | input | 1 | One-cycle strobe: setup packet accepted on endpoint 0 |
| ep1_rx_valid | input | 1 | Live: endpoint 1 FIFO holds a received packet |
| ep2_tx_free | input | 1 | Live: an endpoint 2 transmit buffer is free |
| wr_en | input | 1 | Register write strobe |
| addr | input | 1 | Register select: 0 status, 1 enable mask |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data of the selected register |
| irq | output | 1 | Registered interrupt request |

## Verification
The bench sweeps all 256 enable masks. Each mask is paired with a different combination of event pulses, FIFO levels and clearing-write patterns. This separates a mask bit that is ignored from a flag that never sets. Directed steps send an event pulse alone, a clear alone, and both together. Comparing these three cases shows whether the set takes priority over the clear, and whether a clear reaches only the bits written as 0. Writes of all ones and of all zeros to the status address check that the reserved bits and the two FIFO bits stay independent of software.

// File: rtl/usb_irq_pkg.sv
package usb_irq_pkg;
    localparam int REG_W       = 8;
    localparam int NUM_STICKY  = 3;
    localparam int POS_BUSRST  = 7;
    localparam int POS_EP1FULL = 6;
    localparam int POS_EP2REQ  = 5;
    localparam int POS_EP2FREE = 4;
    localparam int POS_SETUP   = 3;
    localparam logic [REG_W-1:0] EN_RESET = '0;

    typedef enum logic {
        SEL_STATUS = 1'b0,
        SEL_ENABLE = 1'b1
    } reg_sel_e;

    // sticky slot index -> status bit position
    function automatic int sticky_pos(input int idx);
        case (idx)
            0:       return POS_BUSRST;
            1:       return POS_EP2REQ;
            default: return POS_SETUP;
        endcase
    endfunction
endpackage

// File: rtl/usb_irq_sticky.sv
module usb_irq_sticky (
    input  logic clk,
    input  logic rst_n,
    input  logic set_evt,
    input  logic clr_wr,
    input  logic keep_bit,
    output logic flag
);
    typedef struct packed {
        logic flag;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_wr && !keep_bit) begin
            st_d.flag = 1'b0;
        end
        if (set_evt) begin
            st_d.flag = 1'b1;   // a set outranks a clear in the same cycle
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag = st_q.flag;
endmodule

// File: rtl/usb_irq_mirror.sv
module usb_irq_mirror #(
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic live,
    output logic level
);
    typedef struct packed {
        logic level;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.level = live;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.level <= RST_VAL;
        end else begin
            st_q <= st_d;
        end
    end

    assign level = st_q.level;
endmodule

// File: rtl/usb_irq_mask.sv
module usb_irq_mask #(
    parameter int W = 8,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en_wr,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] flags,
    output logic [W-1:0] mask,
    output logic         irq
);
    typedef struct packed {
        logic [W-1:0] mask;
        logic         irq;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.irq = |(flags & st_q.mask);
        if (en_wr) begin
            st_d.mask = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.mask <= RST_VAL;
            st_q.irq  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mask = st_q.mask;
    assign irq  = st_q.irq;
endmodule

// File: rtl/usb_irq_flags.sv
module usb_irq_flags
    import usb_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_reset_evt,
    input  logic             ep2_nodata_evt,
    input  logic             setup_done_evt,
    input  logic             ep1_rx_valid,
    input  logic             ep2_tx_free,
    input  logic             wr_en,
    input  logic             addr,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] rdata,
    output logic             irq
);
    logic [NUM_STICKY-1:0] evt_vec;
    logic [NUM_STICKY-1:0] sticky_q;
    logic                  ep1_lvl;
    logic                  ep2_lvl;
    logic                  wr_status;
    logic                  wr_enable;
    logic [REG_W-1:0]      flags_q;
    logic [REG_W-1:0]      en_q;

    assign evt_vec   = {setup_done_evt, ep2_nodata_evt, bus_reset_evt};
    assign wr_status = wr_en && (reg_sel_e'(addr) == SEL_STATUS);
    assign wr_enable = wr_en && (reg_sel_e'(addr) == SEL_ENABLE);

    for (genvar g = 0; g < NUM_STICKY; g++) begin : g_sticky
        usb_irq_sticky u_flag (
            .clk      (clk),
            .rst_n    (rst_n),
            .set_evt  (evt_vec[g]),
            .clr_wr   (wr_status),
            .keep_bit (wdata[sticky_pos(g)]),
            .flag     (sticky_q[g])
        );
    end

    usb_irq_mirror #(.RST_VAL(1'b0)) u_ep1 (
        .clk   (clk),
        .rst_n (rst_n),
        .live  (ep1_rx_valid),
        .level (ep1_lvl)
    );

    usb_irq_mirror #(.RST_VAL(1'b1)) u_ep2 (
        .clk   (clk),
        .rst_n (rst_n),
        .live  (ep2_tx_free),
        .level (ep2_lvl)
    );

    always_comb begin
        flags_q = '0;
        for (int i = 0; i < NUM_STICKY; i++) begin
            flags_q[sticky_pos(i)] = sticky_q[i];
        end
        flags_q[POS_EP1FULL] = ep1_lvl;
        flags_q[POS_EP2FREE] = ep2_lvl;
    end

    usb_irq_mask #(.W(REG_W), .RST_VAL(EN_RESET)) u_mask (
        .clk   (clk),
        .rst_n (rst_n),
        .en_wr (wr_enable),
        .wdata (wdata),
        .flags (flags_q),
        .mask  (en_q),
        .irq   (irq)
    );

    always_comb begin
        if (reg_sel_e'(addr) == SEL_ENABLE) begin
            rdata = en_q;
        end else begin
            rdata = flags_q;
        end
    end
endmodule

// File: rtl/usb_irq_flags_chk.sv
module usb_irq_flags_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       bus_reset_evt,
    input logic       ep2_nodata_evt,
    input logic       setup_done_evt,
    input logic       ep1_rx_valid,
    input logic       ep2_tx_free,
    input logic       wr_en,
    input logic       addr,
    input logic [7:0] wdata,
    input logic [7:0] rdata,
    input logic [7:0] flags_q,
    input logic [7:0] en_q,
    input logic       irq
);
    logic armed;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    // R2
    ep1_mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> flags_q[6] == $past(ep1_rx_valid));

    // R3
    ep2_mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> flags_q[4] == $past(ep2_tx_free));

    // R4
    busrst_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        armed && $past(bus_reset_evt) |-> flags_q[7]);

    // R5
    busrst_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        armed && $past(wr_en && !addr && !wdata[7] && !bus_reset_evt) |-> !flags_q[7]);

    // R6
    setup_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        armed && $past(setup_done_evt && wr_en && !addr && !wdata[3]) |-> flags_q[3]);

    // R7
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flags_q[2:0] == 3'b000);

    // R8
    enable_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        armed && $past(wr_en && addr) |-> en_q == $past(wdata));

    // R9
    irq_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> irq == $past(|(flags_q & en_q)));
endmodule

bind usb_irq_flags usb_irq_flags_chk chk_i (.*);

// File: tb/usb_irq_flags_test.sv
`timescale 1ns/1ps
module usb_irq_flags_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_reset_evt = 1'b0;
    logic       ep2_nodata_evt = 1'b0;
    logic       setup_done_evt = 1'b0;
    logic       ep1_rx_valid = 1'b0;
    logic       ep2_tx_free = 1'b0;
    logic       wr_en = 1'b0;
    logic       addr = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       irq;

    int total = 0;
    int bad = 0;
    bit done = 0;

    logic [7:0] m_flags;
    logic [7:0] m_en;
    logic       m_irq;

    always #2.5 clk = ~clk;

    usb_irq_flags uut (
        .clk(clk), .rst_n(rst_n),
        .bus_reset_evt(bus_reset_evt), .ep2_nodata_evt(ep2_nodata_evt),
        .setup_done_evt(setup_done_evt), .ep1_rx_valid(ep1_rx_valid),
        .ep2_tx_free(ep2_tx_free), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%02h expected=%02h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic check_all();
        addr = 1'b0; #0.5;
        chk("R2,R3,R4,R5,R6,R7,R10 status", rdata, m_flags);
        addr = 1'b1; #0.5;
        chk("R8,R10 enable", rdata, m_en);
        chk("R9 irq", {7'b0, irq}, {7'b0, m_irq});
    endtask

    // ev: [2] bus reset (bit 7), [1] ep2 no data (bit 5), [0] setup (bit 3)
    task automatic step(input logic [2:0] ev, input logic e1, input logic e2,
                        input logic we, input logic a, input logic [7:0] wd);
        logic [7:0] nf;
        logic [7:0] keep;
        @(negedge clk);
        bus_reset_evt = ev[2]; ep2_nodata_evt = ev[1]; setup_done_evt = ev[0];
        ep1_rx_valid = e1; ep2_tx_free = e2;
        wr_en = we; addr = a; wdata = wd;
        @(posedge clk);
        m_irq = |(m_flags & m_en);
        keep = (we && !a) ? wd : 8'hFF;
        nf = 8'h00;
        nf[7] = (m_flags[7] & keep[7]) | ev[2];
        nf[5] = (m_flags[5] & keep[5]) | ev[1];
        nf[3] = (m_flags[3] & keep[3]) | ev[0];
        nf[6] = e1;
        nf[4] = e2;
        m_flags = nf;
        if (we && a) m_en = wd;
        #1;
        bus_reset_evt = 1'b0; ep2_nodata_evt = 1'b0; setup_done_evt = 1'b0;
        wr_en = 1'b0;
        check_all();
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R1: reset value independent of FIFO inputs
        ep1_rx_valid = 1'b1; ep2_tx_free = 1'b0;
        #12;
        addr = 1'b0; #0.5;
        chk("R1 status in reset", rdata, 8'h10);
        addr = 1'b1; #0.5;
        chk("R1 enable in reset", rdata, 8'h00);
        chk("R1 irq in reset", {7'b0, irq}, 8'h00);
        m_flags = 8'h10; m_en = 8'h00; m_irq = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        ep1_rx_valid = 1'b0; ep2_tx_free = 1'b1;

        // R4 each event alone, R5 clear each, R6 set with clear
        step(3'b100, 0, 1, 0, 0, 8'h00);
        step(3'b010, 0, 1, 0, 0, 8'h00);
        step(3'b001, 0, 1, 0, 0, 8'h00);
        step(3'b000, 0, 1, 1, 0, 8'h7F);          // R5 clear bit 7 only
        step(3'b000, 0, 1, 1, 0, 8'hF7);          // R5 clear bit 3 only
        step(3'b001, 0, 1, 1, 0, 8'h00);          // R6 set wins, bit 5 cleared
        step(3'b000, 1, 0, 1, 0, 8'h00);          // R2/R3 live, R7
        step(3'b000, 1, 0, 1, 0, 8'hFF);          // R7 reserved ignore 1s
        step(3'b000, 0, 1, 1, 1, 8'hA5);          // R8
        step(3'b000, 0, 1, 1, 0, 8'h00);          // R8 mask kept
        step(3'b111, 1, 1, 0, 0, 8'h00);          // R9

        // sweep every enable mask with varied flag activity
        for (int e = 0; e < 256; e++) begin
            logic [7:0] ev8;
            ev8 = 8'(e * 37 + 11);
            step(3'b000, ev8[6], ev8[7], 1, 1, 8'(e));
            step(ev8[2:0] ^ ev8[5:3], ev8[7], ev8[6], 0, 0, 8'h00);
            step(3'b000, ev8[3], ev8[1], 1, 0, ~ev8);
            step(ev8[4:2], ev8[5], ev8[0], 1, 0, ev8);
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule